// File: doc/BRIEF.md
# Sync-Presence Display Power-State Controller

This block watches the horizontal and vertical sync lines of a display input and picks one of four power states. The choice depends on which of the two syncs is currently active. The state drives three things: the colour of a front-panel indicator (green or amber), the enable of an auxiliary supply rail, and a video blanking request.

The blanking request combines three independent causes:
- any power-saving state;
- a timed hold that starts on a mode-change pulse from an external frequency meter;
- the vertical-retrace flag.

All timing is counted in ticks of a 1 ms strobe. The clock can therefore run at any rate. The sync inputs are expected to be synchronized to the clock already.

Presence is judged per sync line from its rising edges:
- A line that shows no rising edge for the absence window becomes absent.
- An absent line becomes present again after a short run of rising edges.
- The gap between consecutive edges in that run must stay shorter than the absence window. If a full window passes with no edge, the run is discarded.

Top module: `sync_power_ctrl`

## Requirements
- R1: `pwr_state` has bit 0 set when HSYNC is absent and bit 1 set when VSYNC is absent. This gives 2'b00 = Normal (both present), 2'b01 = Stand-by (only VSYNC present), 2'b10 = Suspend (only HSYNC present) and 2'b11 = Off (both absent).
- R2: `led_amber` is 0 (green) in Normal and 1 (amber) in the other three states.
- R3: `supply_en` is 1 in Normal and 0 whenever either sync is absent.
- R4: After reset the state is Off (2'b11), with `led_amber` = 1, `supply_en` = 0 and `blank` = 1.
- R5: A present sync becomes absent on the 100th tick after its last rising edge with no rising edge in between. After 99 such ticks it is still present. A rising edge in the same cycle as a tick counts as an edge.
- R6: An absent sync becomes present on its 4th rising edge, provided each edge comes fewer than 100 ticks after the previous one. Three edges are not enough. A run of 100 ticks with no edge discards the edges collected so far.
- R7: A `mode_chg` pulse makes `blank` 1 from the next cycle until 200 ticks have elapsed. After 199 ticks it is still 1. A new pulse during the hold restarts the full 200 ticks.
- R8: `blank` is 1 whenever `pwr_state` is not Normal.
- R9: `blank` is 1 in every cycle where `vretrace` is 1, with no added latency.
- R10: In Normal, with `vretrace` low and no mode-change hold running, `blank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| hsync | input | 1 | Synchronized horizontal sync level |
| vsync | input | 1 | Synchronized vertical sync level |
| mode_chg | input | 1 | One-cycle pulse when the display mode changes |
| vretrace | input | 1 | High during vertical retrace |
| pwr_state | output | 2 | Power state, encoded as in R1 |
| led_amber | output | 1 | Indicator colour: 0 green, 1 amber |
| supply_en | output | 1 | Enable for the auxiliary 14 V rail |
| blank | output | 1 | Video blanking request |

## Verification
The assertions check the following on every cycle:
- the pairing of indicator colour and supply enable with the state;
- that a non-Normal state, a retrace or a fresh mode-change pulse always yields `blank`;
- that a line only turns present on a rising edge and only turns absent on a tick with no edge.

Exact tick counts need the bench's scenarios:
- the 99/100-tick absence boundary;
- the 3-versus-4-edge rule;
- the discarding of a partial edge run after a silent window;
- the 199/200-tick mode-blank hold and its restart.

The state decode across all four combinations of sync presence is walked from a table.

// File: rtl/sync_power_pkg.sv
package sync_power_pkg;

    typedef enum logic [1:0] {
        PS_NORMAL  = 2'b00,
        PS_STANDBY = 2'b01,
        PS_SUSPEND = 2'b10,
        PS_OFF     = 2'b11
    } pwr_state_e;

    localparam int unsigned CH_H   = 0;
    localparam int unsigned CH_V   = 1;
    localparam int unsigned NUM_CH = 2;

    typedef struct packed {
        logic led_amber;
        logic supply_en;
    } pwr_drive_t;

    // bit0 flags a missing horizontal sync, bit1 a missing vertical sync
    function automatic pwr_state_e state_from_presence(logic h_ok, logic v_ok);
        return pwr_state_e'({~v_ok, ~h_ok});
    endfunction

    function automatic pwr_drive_t drive_for(pwr_state_e s);
        pwr_drive_t d;
        d.led_amber = (s != PS_NORMAL);
        d.supply_en = (s == PS_NORMAL);
        return d;
    endfunction

endpackage

// File: rtl/sync_presence.sv
module sync_presence #(
    parameter int unsigned ABSENT_TICKS = 100,
    parameter int unsigned ARM_EDGES    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sync_lvl,
    output logic present
);
    localparam int unsigned IW = $clog2(ABSENT_TICKS + 1);
    localparam int unsigned EW = $clog2(ARM_EDGES + 1);

    logic          prev_lvl;
    logic [IW-1:0] idle_ticks;
    logic [EW-1:0] edge_run;
    logic          present_q;
    logic          rise;

    assign rise    = sync_lvl & ~prev_lvl;
    assign present = present_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl   <= 1'b0;
            idle_ticks <= '0;
            edge_run   <= '0;
            present_q  <= 1'b0;
        end else begin
            prev_lvl <= sync_lvl;
            if (rise) begin
                idle_ticks <= '0;
                if (!present_q) begin
                    if (edge_run == EW'(ARM_EDGES - 1)) begin
                        present_q <= 1'b1;
                        edge_run  <= '0;
                    end else begin
                        edge_run <= edge_run + 1'b1;
                    end
                end
            end else if (tick) begin
                if (idle_ticks == IW'(ABSENT_TICKS - 1)) begin
                    idle_ticks <= '0;
                    edge_run   <= '0;
                    present_q  <= 1'b0;
                end else begin
                    idle_ticks <= idle_ticks + 1'b1;
                end
            end
        end
    end

    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(present_q) |-> $past(rise)) else $error("present rose without edge"); // R6
    AST_FALL_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(present_q) |-> $past(tick && !rise)) else $error("present fell without quiet tick"); // R5
    AST_NO_RUN_WHILE_UP: assert property (@(posedge clk) disable iff (rst)
        present_q |-> (edge_run == '0)) else $error("edge run kept while present"); // R6

endmodule

// File: rtl/power_decode.sv
module power_decode
    import sync_power_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       h_ok,
    input  logic       v_ok,
    output pwr_state_e state,
    output logic       led_amber,
    output logic       supply_en
);
    pwr_state_e state_q;
    pwr_drive_t drv;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_OFF;
        else     state_q <= state_from_presence(h_ok, v_ok);
    end

    assign drv       = drive_for(state_q);
    assign state     = state_q;
    assign led_amber = drv.led_amber;
    assign supply_en = drv.supply_en;

    AST_STATE_TRACKS_SYNC: assert property (@(posedge clk) disable iff (rst)
        ##1 (state_q[0] == !$past(h_ok)) && (state_q[1] == !$past(v_ok))) else $error("state lag wrong"); // R1

endmodule

// File: rtl/blank_merge.sv
module blank_merge #(
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mode_chg,
    input  logic vretrace,
    input  logic saving,
    output logic blank
);
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] hold_left;
    logic          hold_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_left <= '0;
        end else if (mode_chg) begin
            hold_left <= HW'(HOLD_TICKS);
        end else if (tick && hold_left != '0) begin
            hold_left <= hold_left - 1'b1;
        end
    end

    assign hold_active = (hold_left != '0);
    assign blank       = hold_active | saving | vretrace;

    AST_HOLD_DRAINS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_active) |-> $past(tick && !mode_chg)) else $error("hold ended off tick"); // R7

endmodule

// File: rtl/sync_power_ctrl.sv
module sync_power_ctrl
    import sync_power_pkg::*;
#(
    parameter int unsigned ABSENT_MS    = 100,
    parameter int unsigned ARM_EDGES    = 4,
    parameter int unsigned MODE_HOLD_MS = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1ms,
    input  logic       hsync,
    input  logic       vsync,
    input  logic       mode_chg,
    input  logic       vretrace,
    output logic [1:0] pwr_state,
    output logic       led_amber,
    output logic       supply_en,
    output logic       blank
);
    logic [NUM_CH-1:0] sync_lvls;
    logic [NUM_CH-1:0] sync_ok;
    pwr_state_e        state;

    assign sync_lvls[CH_H] = hsync;
    assign sync_lvls[CH_V] = vsync;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sync_presence #(
            .ABSENT_TICKS (ABSENT_MS),
            .ARM_EDGES    (ARM_EDGES)
        ) u_pres (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_1ms),
            .sync_lvl (sync_lvls[c]),
            .present  (sync_ok[c])
        );
    end

    power_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .h_ok      (sync_ok[CH_H]),
        .v_ok      (sync_ok[CH_V]),
        .state     (state),
        .led_amber (led_amber),
        .supply_en (supply_en)
    );

    assign pwr_state = state;

    blank_merge #(
        .HOLD_TICKS (MODE_HOLD_MS)
    ) u_blank (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1ms),
        .mode_chg (mode_chg),
        .vretrace (vretrace),
        .saving   (state != PS_NORMAL),
        .blank    (blank)
    );

    AST_AMBER_OFF_NORMAL: assert property (@(posedge clk) disable iff (rst)
        led_amber == (pwr_state != 2'b00)) else $error("led colour mismatch"); // R2
    AST_SUPPLY_ONLY_NORMAL: assert property (@(posedge clk) disable iff (rst)
        supply_en |-> (pwr_state == 2'b00 && !led_amber)) else $error("supply on while saving"); // R3
    AST_SAVE_BLANKS: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != 2'b00) |-> blank) else $error("saving state not blanked"); // R8
    AST_RETRACE_BLANKS: assert property (@(posedge clk) disable iff (rst)
        vretrace |-> blank) else $error("retrace not blanked"); // R9
    AST_MODE_BLANKS: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> blank) else $error("mode change not blanked"); // R7

endmodule

// File: tb/sync_power_ctrl_test.sv
module sync_power_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0, hsync = 1'b0, vsync = 1'b0, mode_chg = 1'b0, vretrace = 1'b0;
    logic [1:0] pwr_state;
    logic led_amber, supply_en, blank;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_power_ctrl uut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .hsync(hsync), .vsync(vsync),
        .mode_chg(mode_chg), .vretrace(vretrace), .pwr_state(pwr_state),
        .led_amber(led_amber), .supply_en(supply_en), .blank(blank)
    );

    // {h_on, v_on, exp_state[1:0], exp_amber, exp_supply}
    localparam logic [5:0] PATTERNS [6] = '{
        {2'b11, 2'b00, 1'b0, 1'b1},
        {2'b01, 2'b01, 1'b1, 1'b0},
        {2'b10, 2'b10, 1'b1, 1'b0},
        {2'b00, 2'b11, 1'b1, 1'b0},
        {2'b11, 2'b00, 1'b0, 1'b1},
        {2'b10, 2'b10, 1'b1, 1'b0}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one tick cycle with chosen syncs high, then one quiet cycle
    task automatic step(logic t, logic h, logic v);
        @(negedge clk); tick_1ms = t; hsync = h; vsync = v;
        @(negedge clk); tick_1ms = 1'b0; hsync = 1'b0; vsync = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic establish(logic h, logic v);
        for (int i = 0; i < 100; i++) step(1'b1, h, v);
        idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        // R4: reset state
        check("R4 state", 8'(pwr_state), 8'h3);
        check("R4 amber", 8'(led_amber), 8'h1);
        check("R4 supply", 8'(supply_en), 8'h0);
        check("R4 blank", 8'(blank), 8'h1);
        @(negedge clk); rst = 1'b0;
        idle(2);
        check("R4 off after release", 8'(pwr_state), 8'h3);

        // R1 R2 R3 R8 R10: table of presence patterns
        for (int i = 0; i < 6; i++) begin
            logic [5:0] p;
            p = PATTERNS[i];
            establish(p[5], p[4]);
            check("R1 state decode", 8'(pwr_state), 8'(p[3:2]));
            check("R2 led colour", 8'(led_amber), 8'(p[1]));
            check("R3 supply enable", 8'(supply_en), 8'(p[0]));
            check(p[3:2] == 2'b00 ? "R10 no blank in normal" : "R8 blank when saving",
                  8'(blank), 8'(p[3:2] != 2'b00));
        end

        // R5: absence boundary at 100 quiet ticks
        establish(1'b1, 1'b1);
        for (int i = 0; i < 99; i++) step(1'b1, 1'b0, 1'b0);
        idle(3);
        check("R5 present after 99 ticks", 8'(pwr_state), 8'h0);
        step(1'b1, 1'b0, 1'b0);
        idle(3);
        check("R5 absent after 100 ticks", 8'(pwr_state), 8'h3);

        // R6: three edges not enough, fourth arms hsync
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        idle(3);
        check("R6 three edges", 8'(pwr_state), 8'h3);
        step(1'b0, 1'b1, 1'b0);
        idle(3);
        check("R6 fourth edge", 8'(pwr_state), 8'h2);

        // R6: silent window discards a partial vsync run
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        idle(3);
        check("R6 run discarded", 8'(pwr_state), 8'h2);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1);
        idle(3);
        check("R6 three fresh edges", 8'(pwr_state), 8'h2);
        step(1'b0, 1'b0, 1'b1);
        idle(3);
        check("R6 fresh fourth edge", 8'(pwr_state), 8'h0);
        check("R10 normal unblanked", 8'(blank), 8'h0);

        // R7: mode-change hold of 200 ticks
        @(negedge clk); mode_chg = 1'b1;
        @(negedge clk); mode_chg = 1'b0;
        check("R7 blank after pulse", 8'(blank), 8'h1);
        for (int i = 0; i < 199; i++) step(1'b1, 1'b1, 1'b1);
        check("R7 blank at 199 ticks", 8'(blank), 8'h1);
        step(1'b1, 1'b1, 1'b1);
        check("R7 clear at 200 ticks", 8'(blank), 8'h0);

        // R7: restart during hold
        @(negedge clk); mode_chg = 1'b1;
        @(negedge clk); mode_chg = 1'b0;
        for (int i = 0; i < 150; i++) step(1'b1, 1'b1, 1'b1);
        @(negedge clk); mode_chg = 1'b1;
        @(negedge clk); mode_chg = 1'b0;
        for (int i = 0; i < 199; i++) step(1'b1, 1'b1, 1'b1);
        check("R7 restart held", 8'(blank), 8'h1);
        step(1'b1, 1'b1, 1'b1);
        check("R7 restart clear", 8'(blank), 8'h0);
        check("R7 still normal", 8'(pwr_state), 8'h0);

        // R9: retrace blanks in the same cycle
        @(negedge clk); vretrace = 1'b1;
        #1 check("R9 retrace blank", 8'(blank), 8'h1);
        @(negedge clk); vretrace = 1'b0;
        #1 check("R9 retrace released", 8'(blank), 8'h0);

        // R4: reset mid-run returns to Off
        @(negedge clk); rst = 1'b1;
        idle(2);
        check("R4 re-reset state", 8'(pwr_state), 8'h3);
        check("R4 re-reset supply", 8'(supply_en), 8'h0);

        finish_run();
    end
endmodule